// File: doc/BRIEF.md
# Multiplicative Congruential State-Table Seeder

This block expands one 32-bit seed into the 31-word state table that a lagged additive random generator needs before it can start. Word 0 is the seed. Each later word is the previous word times 16807, reduced modulo the Mersenne prime 2^31−1. The engine produces one word per clock, so a complete table is ready about every 31 cycles. Several downstream generators can share one seeder that way. The warm-up rounds and the production of output numbers belong to those downstream engines.

No divider is used. The product of the current word and the constant is split at bit 31. The upper part is added back onto the lower 31 bits, and the modulus is subtracted once more if the sum still reaches it. A consumer pulses a start strobe with a seed present. It then receives 31 consecutive word strobes, each with a 5-bit index and a value. A done pulse comes with the last word. A new start can be given in that same done cycle, so tables can follow each other with no idle clock between them.

Top module: `lcg_seed_engine`

## Requirements
- R1: While reset is asserted (asynchronous, active-low `rst_n`), and after it is released, `busy_o`, `word_vld_o` and `done_o` are 0 until a start is accepted.
- R2: A start pulse with `busy_o` low is accepted at that clock edge. In the next cycle `busy_o` and `word_vld_o` are 1, `word_idx_o` is 0 and `word_o` equals the seed.
- R3: A seed of zero is replaced by 1, so word 0 is 1 and the table never collapses to all zeros.
- R4: For index i from 1 to 30, `word_o` equals (16807 × word i−1) mod 2147483647, and its value is always below 2147483647.
- R5: After a start, `word_vld_o` stays high for 31 consecutive cycles, while `word_idx_o` counts 0, 1, …, 30 in ascending order.
- R6: `done_o` is high for exactly one cycle: the cycle that presents index 30.
- R7: A start pulse while `busy_o` is high and `done_o` is low is ignored. The index and the word sequence continue unchanged.
- R8: A start pulse in the `done_o` cycle is accepted. In the next cycle index 0 carries the new seed and `busy_o` stays high.
- R9: If no start arrives in the `done_o` cycle, `busy_o` and `word_vld_o` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to expand `seed_i` |
| seed_i | input | 32 | Seed value, sampled on an accepted start |
| busy_o | output | 1 | Expansion in progress |
| word_vld_o | output | 1 | `word_o` and `word_idx_o` carry a state word |
| word_idx_o | output | 5 | Index of the presented state word, 0 to 30 |
| word_o | output | 32 | Value of the presented state word |
| done_o | output | 1 | Pulse alongside the final word (index 30) |

## Verification
Two functions can fall in the same cycle: finishing the current table, which is the done pulse with index 30, and accepting the next seed. The bench provokes this by raising the start strobe in exactly the cycle where it sees `done_o`. It then checks that the next cycle shows index 0 with the new seed and that `busy_o` never dropped. It also checks a start raised in the middle of a table and confirms that the index and values do not change.

// File: rtl/lcg_seed_pkg.sv
package lcg_seed_pkg;

  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_NWORDS = 31;
  localparam int unsigned DEF_MULT   = 16807;

  // A zero seed would pin every word at zero; substitute 1 instead.
  function automatic logic [DEF_WORD_W-1:0] seed_fix(input logic [DEF_WORD_W-1:0] s);
    return (s == '0) ? DEF_WORD_W'(1) : s;
  endfunction

endpackage

// File: rtl/lcg_mulmod.sv
module lcg_mulmod #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned MULT   = 16807
) (
  input  logic [WORD_W-1:0] x_i,
  output logic [WORD_W-1:0] y_o
);
  localparam int unsigned MW   = $clog2(MULT + 1);
  localparam int unsigned PW   = WORD_W + MW;
  localparam int unsigned MODW = WORD_W - 1;
  localparam logic [PW-1:0] MODV = PW'({MODW{1'b1}});

  logic [PW-1:0] prod;
  logic [PW-1:0] lo_part;
  logic [PW-1:0] hi_part;
  logic [PW-1:0] folded;
  logic [PW-1:0] reduced;

  // The 2^MODW weight of the upper bits is congruent to 1, so they fold onto the low bits.
  always_comb begin
    prod    = PW'(x_i) * PW'(MULT);
    lo_part = PW'(prod[MODW-1:0]);
    hi_part = prod >> MODW;
    folded  = lo_part + hi_part;
    reduced = (folded >= MODV) ? (folded - MODV) : folded;
  end

  assign y_o = WORD_W'(reduced);

endmodule

// File: rtl/lcg_seq_ctrl.sv
module lcg_seq_ctrl #(
  parameter int unsigned NWORDS = 31,
  parameter int unsigned IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] PENULT = IDX_W'(NWORDS - 2);

  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] idx_q;

  assign accept_o = start_i && (!busy_q || done_q);
  assign step_o   = busy_q && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else if (done_q) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else if (step_o) begin
      idx_q  <= idx_q + IDX_W'(1);
      done_q <= (idx_q == PENULT);
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/lcg_word_reg.sv
module lcg_word_reg
  import lcg_seed_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned MULT   = DEF_MULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] seed_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] next_w;
  logic [WORD_W-1:0] seed_w;

  lcg_mulmod #(.WORD_W(WORD_W), .MULT(MULT)) u_mulmod (
    .x_i (word_q),
    .y_o (next_w)
  );

  generate
    if (WORD_W == DEF_WORD_W) begin : g_pkg_fix
      assign seed_w = seed_fix(seed_i);
    end else begin : g_local_fix
      assign seed_w = (seed_i == '0) ? WORD_W'(1) : seed_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (load_i) word_q <= seed_w;
    else if (step_i) word_q <= next_w;
  end

  assign word_o = word_q;

endmodule

// File: rtl/lcg_seed_engine.sv
module lcg_seed_engine
  import lcg_seed_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned NWORDS = DEF_NWORDS,
  parameter int unsigned MULT   = DEF_MULT,
  parameter int unsigned IDX_W  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] seed_i,
  output logic              busy_o,
  output logic              word_vld_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  // Named internal events, visible to the bound checker.
  logic accept_w;
  logic step_w;
  logic busy_w;

  lcg_seq_ctrl #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept_w),
    .step_o   (step_w),
    .busy_o   (busy_w),
    .done_o   (done_o),
    .idx_o    (word_idx_o)
  );

  lcg_word_reg #(.WORD_W(WORD_W), .MULT(MULT)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_w),
    .step_i (step_w),
    .seed_i (seed_i),
    .word_o (word_o)
  );

  assign busy_o     = busy_w;
  assign word_vld_o = busy_w;

endmodule

// File: rtl/lcg_seed_engine_chk.sv
module lcg_seed_engine_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NWORDS = 31,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [WORD_W-1:0] seed_i,
  input logic              busy_o,
  input logic              word_vld_o,
  input logic [IDX_W-1:0]  word_idx_o,
  input logic [WORD_W-1:0] word_o,
  input logic              done_o,
  input logic              accept_w
);
  localparam logic [WORD_W-1:0] MODV = WORD_W'({(WORD_W-1){1'b1}});
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(NWORDS - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy_o && !word_vld_o && !done_o); // R1
  AST_START_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (word_vld_o && busy_o && word_idx_o == '0)); // R2
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && seed_i == '0) |=> (word_o == WORD_W'(1))); // R3
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && word_idx_o != '0) |-> (word_o < MODV)); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && !done_o) |=> (word_vld_o && word_idx_o == $past(word_idx_o) + IDX_W'(1))); // R5
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (word_vld_o && word_idx_o == LAST)); // R6
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !done_o) |-> !accept_w); // R7
  AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (busy_o && word_idx_o == '0 && word_vld_o)); // R8
  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (!busy_o && !word_vld_o)); // R9

endmodule

bind lcg_seed_engine lcg_seed_engine_chk #(
  .WORD_W (WORD_W),
  .NWORDS (NWORDS),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .seed_i     (seed_i),
  .busy_o     (busy_o),
  .word_vld_o (word_vld_o),
  .word_idx_o (word_idx_o),
  .word_o     (word_o),
  .done_o     (done_o),
  .accept_w   (accept_w)
);

// File: tb/tb_lcg_seed_engine.sv
module tb_lcg_seed_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        busy_o, word_vld_o, done_o;
  logic [4:0]  word_idx_o;
  logic [31:0] word_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lcg_seed_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
    .busy_o(busy_o), .word_vld_o(word_vld_o), .word_idx_o(word_idx_o),
    .word_o(word_o), .done_o(done_o)
  );

  // Vector table: seed and the expected word 0.
  localparam int NVEC = 6;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_002A, 32'h0000_002A},
    {32'h7FFF_FFFE, 32'h7FFF_FFFE},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h1234_5678, 32'h1234_5678},
    {32'h0000_0000, 32'h0000_0001}
  };

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one table expansion and checks all 31 words.
  task automatic run_seq(input logic [31:0] seed, input logic [31:0] exp0, input bit pre,
                         input int poke, input bit chain, input logic [31:0] nseed);
    longint unsigned w;
    if (!pre) begin
      start_i = 1'b1;
      seed_i  = seed;
    end
    @(negedge clk);
    start_i = 1'b0;
    w = exp0;
    for (int i = 0; i < 31; i++) begin
      if (i > 0) begin
        @(negedge clk);
        start_i = 1'b0;
        w = (w * 64'd16807) % 64'd2147483647;
      end
      chk(word_vld_o == 1'b1, "R5 valid", word_vld_o, 1);
      chk(word_idx_o == 5'(i), (i == poke + 1) ? "R7 index" : "R5 index", word_idx_o, i);
      chk(word_o == 32'(w), (i == 0) ? ((seed == 0) ? "R3 word0" : "R2 word0") : "R4 word",
          word_o, w);
      chk(done_o == (i == 30), "R6 done", done_o, (i == 30));
      chk(busy_o == 1'b1, (pre && i == 0) ? "R8 busy" : "R2 busy", busy_o, 1);
      if (i == poke) begin start_i = 1'b1; seed_i = 32'hDEAD_BEEF; end
      if (i == 30 && chain) begin start_i = 1'b1; seed_i = nseed; end
    end
    if (!chain) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b0, "R9 busy", busy_o, 0);
      chk(word_vld_o == 1'b0, "R9 valid", word_vld_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !word_vld_o && !done_o, "R1 in reset", {busy_o, word_vld_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !word_vld_o && !done_o, "R1 after release", {busy_o, word_vld_o, done_o}, 0);

    // Vector walk.
    for (int v = 0; v < NVEC; v++) begin
      run_seq(VEC[v][63:32], VEC[v][31:0], 1'b0, -5, 1'b0, 32'h0);
      @(negedge clk);
    end

    // R7: start raised mid-table is ignored.
    run_seq(32'h0000_BEEF, 32'h0000_BEEF, 1'b0, 10, 1'b0, 32'h0);

    // R8: start in the done cycle chains straight into the next table.
    run_seq(32'h0000_0007, 32'h0000_0007, 1'b0, -5, 1'b1, 32'h0000_0000);
    run_seq(32'h0000_0000, 32'h0000_0001, 1'b1, -5, 1'b1, 32'h0BAD_CAFE);
    run_seq(32'h0BAD_CAFE, 32'h0BAD_CAFE, 1'b1, -5, 1'b0, 32'h0);

    // R1: reset in the middle of a table.
    start_i = 1'b1; seed_i = 32'd99;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !word_vld_o && !done_o, "R1 mid reset", {busy_o, word_vld_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !word_vld_o, "R1 stays idle", {busy_o, word_vld_o}, 0);

    // Fresh table after reset.
    run_seq(32'h0000_0003, 32'h0000_0003, 1'b0, -5, 1'b0, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule